// File: doc/BRIEF.md
# Reset Vector Sequencer

This block brings a processor with a 16-bit data bus out of reset. Once reset is released, it keeps the bus quiet for a fixed number of microcycles. It then enters supervisor state with all interrupts masked and tracing off. Next it fetches the starting supervisor stack pointer and program counter from the bottom of the address space, one word at a time. After that it fills a two-word instruction prefetch queue, and finally it pulses a strobe that hands control to instruction decode.

Each bus access is a word read over a request/acknowledge handshake. The block raises `bus_req` with an address, a space flag and both byte lanes, and holds them until `bus_ack` is sampled high on a rising clock edge. The read data is captured on that same edge. One clock is one half-cycle, so a microcycle lasts `HALF_PER_UCYC` clocks.

The sequencer is a single enumerated state machine with these states:

- `ST_RST_IDLE`: counts the reset idle window.
- `ST_FORCE`: sets the status fields and swaps in the supervisor stack bank.
- `ST_VEC`: performs the four vector reads.
- `ST_PF_A`: performs the first prefetch.
- `ST_GAP`: waits one idle microcycle.
- `ST_PF_B`: performs the second prefetch.
- `ST_DONE`: emits the decode strobe.
- `ST_HALT`: parks the sequencer.

The transitions are:

- `ST_RST_IDLE` to `ST_FORCE` when the timer expires.
- `ST_FORCE` to `ST_VEC` unconditionally.
- `ST_VEC` to `ST_PF_A` on the fourth acknowledge.
- `ST_PF_A` to `ST_GAP` on its acknowledge.
- `ST_GAP` to `ST_PF_B` when the timer expires.
- `ST_PF_B` to `ST_DONE` on its acknowledge.
- `ST_DONE` to `ST_HALT` unconditionally.
- `ST_HALT` stays in `ST_HALT`.
- Any state returns to `ST_RST_IDLE` whenever reset is asserted.

Top module: `boot_vector_seq`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `decode_go` and `supervisor` are 0, and `a7_out`, `pc_out` and `usp_out` are 0.
- R2: After reset is released, `bus_req` stays low for exactly RESET_UCYC*HALF_PER_UCYC + 1 rising edges, which is 29 with the defaults. It goes high after the 29th edge.
- R3: From the first bus request on, `supervisor` is 1, `int_mask` is all ones (7) and `trace` is 0.
- R4: The first four requests are data-space reads (`bus_prog` = 0) at addresses 0, 2, 4 and 6, in that order. The stack pointer is {word@0, word@2}, shown on `a7_out`. The program counter is {word@4, word@6}, shown on `pc_out`.
- R5: Every request drives `bus_lanes` = 2'b11. A request with no acknowledge keeps `bus_req` high and `bus_addr` unchanged on the next cycle.
- R6: The two prefetches are program-space reads (`bus_prog` = 1) at the loaded PC and at PC+2. Each acknowledged prefetch moves `queue_lo` into `queue_hi`, loads the read word into `queue_lo`, and adds 2 to `pc_out`. At the end, `pc_out` is the vector PC + 4.
- R7: Between the first prefetch's acknowledge and the second prefetch's request, `bus_req` is low for exactly GAP_UCYC*HALF_PER_UCYC cycles, which is 4.
- R8: `decode_go` is high for exactly one cycle, the cycle after the second prefetch's acknowledge edge. After it, no request is made until the next reset.
- R9: Entering supervisor state saves the prior user-mode A7 (0 after reset) into the user bank, shown on `usp_out`, and reloads A7 from the supervisor bank. The vector then overwrites A7.
- R10: Asserting reset in the middle of the vector reads drops `bus_req` at once and clears partially loaded registers. The next release restarts the full idle window with a read at address 0.
- R11: Final register and queue contents do not depend on how many cycles each acknowledge is delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one half-cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Word read request |
| bus_addr | output | ADDR_W | Byte address of the read |
| bus_prog | output | 1 | 1 = program space, 0 = data space |
| bus_lanes | output | 2 | Byte lane enables, upper then lower |
| bus_ack | input | 1 | Read acknowledge, data valid on this edge |
| bus_rdata | input | 16 | Read data word |
| a7_out | output | 32 | Active stack pointer |
| usp_out | output | 32 | Saved user-mode stack pointer bank |
| pc_out | output | 32 | Program counter |
| supervisor | output | 1 | Supervisor state bit |
| int_mask | output | 3 | Interrupt mask level |
| trace | output | 1 | Trace flag |
| queue_hi | output | 16 | Older prefetch queue word |
| queue_lo | output | 16 | Newer prefetch queue word |
| decode_go | output | 1 | One-cycle strobe that starts decode |

## Verification
Most state errors appear at the ports within one bus transaction. A wrong vector index shows up on `bus_addr` during the very next request. A wrong word-half select corrupts `a7_out` or `pc_out` one edge after the acknowledge. A timer that miscounts moves the first request, or the second prefetch request, earlier or later by a whole cycle. A stuck state shows up as a missing `decode_go` strobe, a repeated one, or requests after it. The bench varies the acknowledge delay so that stall handling and data capture are exercised separately from sequencing.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_RST_IDLE,
        ST_FORCE,
        ST_VEC,
        ST_PF_A,
        ST_GAP,
        ST_PF_B,
        ST_DONE,
        ST_HALT
    } boot_state_t;

endpackage

// File: rtl/boot_uc_timer.sv
module boot_uc_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    assign last = run && (cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/boot_sp_bank.sv
module boot_sp_bank #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_cur,
    input  logic              sup_next,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wdata,
    output logic [2*HALF_W-1:0] a7,
    output logic [2*HALF_W-1:0] usp
);
    logic [2*HALF_W-1:0] bank [2];
    logic                swap;

    assign swap = (sup_cur != sup_next);
    assign usp  = bank[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a7      <= '0;
            bank[0] <= '0;
            bank[1] <= '0;
        end else if (swap) begin
            bank[sup_cur] <= a7;
            a7            <= bank[sup_next];
        end else begin
            if (wr_hi) a7[2*HALF_W-1:HALF_W] <= wdata;
            if (wr_lo) a7[HALF_W-1:0]        <= wdata;
        end
    end
endmodule

// File: rtl/boot_prefetch_q.sv
module boot_prefetch_q #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q_hi,
    output logic [W-1:0] q_lo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_hi <= '0;
            q_lo <= '0;
        end else if (push) begin
            q_hi <= q_lo;
            q_lo <= wdata;
        end
    end
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int RESET_UCYC    = 7,
    parameter int GAP_UCYC      = 1,
    parameter int HALF_PER_UCYC = 4,
    parameter int MASK_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_prog,
    output logic [1:0]        bus_lanes,
    input  logic              bus_ack,
    input  logic [15:0]       bus_rdata,
    output logic [31:0]       a7_out,
    output logic [31:0]       usp_out,
    output logic [31:0]       pc_out,
    output logic              supervisor,
    output logic [MASK_W-1:0] int_mask,
    output logic              trace,
    output logic [15:0]       queue_hi,
    output logic [15:0]       queue_lo,
    output logic              decode_go
);
    localparam int DATA_W     = 16;
    localparam int REG_W      = 2 * DATA_W;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int RESET_CLKS = RESET_UCYC * HALF_PER_UCYC;
    localparam int GAP_CLKS   = GAP_UCYC * HALF_PER_UCYC;
    localparam int CNT_W      = $clog2(RESET_CLKS + GAP_CLKS + 1);

    boot_state_t       state, state_nx;
    logic [1:0]        vec_idx;
    logic [REG_W-1:0]  pc_q;
    logic              sup_q, trace_q;
    logic [MASK_W-1:0] mask_q;
    logic              t_run, t_last;
    logic [CNT_W-1:0]  t_limit;
    logic              xfer, vec_xfer, pf_xfer;

    assign xfer     = bus_req && bus_ack;
    assign vec_xfer = xfer && (state == ST_VEC);
    assign pf_xfer  = xfer && (state == ST_PF_A || state == ST_PF_B);

    // Shared microcycle timer for the reset window and the inter-prefetch gap
    assign t_run   = (state == ST_RST_IDLE) || (state == ST_GAP);
    assign t_limit = (state == ST_GAP) ? CNT_W'(GAP_CLKS) : CNT_W'(RESET_CLKS);

    boot_uc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(t_run), .limit(t_limit), .last(t_last)
    );

    boot_sp_bank #(.HALF_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .sup_cur(sup_q),
        .sup_next((state == ST_FORCE) ? 1'b1 : sup_q),
        .wr_hi(vec_xfer && vec_idx == 2'd0),
        .wr_lo(vec_xfer && vec_idx == 2'd1),
        .wdata(bus_rdata),
        .a7(a7_out), .usp(usp_out)
    );

    boot_prefetch_q #(.W(DATA_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(pf_xfer), .wdata(bus_rdata),
        .q_hi(queue_hi), .q_lo(queue_lo)
    );

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RST_IDLE: if (t_last) state_nx = ST_FORCE;
            ST_FORCE:    state_nx = ST_VEC;
            ST_VEC:      if (bus_ack && vec_idx == 2'd3) state_nx = ST_PF_A;
            ST_PF_A:     if (bus_ack) state_nx = ST_GAP;
            ST_GAP:      if (t_last) state_nx = ST_PF_B;
            ST_PF_B:     if (bus_ack) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_HALT;
            ST_HALT:     state_nx = ST_HALT;
        endcase
    end

    // State and architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_RST_IDLE;
            vec_idx <= '0;
            pc_q    <= '0;
            sup_q   <= 1'b0;
            mask_q  <= '0;
            trace_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_FORCE) begin
                sup_q   <= 1'b1;
                mask_q  <= '1;
                trace_q <= 1'b0;
            end
            if (vec_xfer) begin
                vec_idx <= vec_idx + 1'b1;
                if (vec_idx == 2'd2) pc_q[REG_W-1:DATA_W] <= bus_rdata;
                if (vec_idx == 2'd3) pc_q[DATA_W-1:0]     <= bus_rdata;
            end
            if (pf_xfer)
                pc_q <= pc_q + REG_W'(WORD_BYTES);
        end
    end

    // Bus and status outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_prog  = 1'b0;
        bus_addr  = '0;
        decode_go = 1'b0;
        unique case (state)
            ST_VEC: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'({vec_idx, 1'b0});
            end
            ST_PF_A, ST_PF_B: begin
                bus_req  = 1'b1;
                bus_prog = 1'b1;
                bus_addr = pc_q[ADDR_W-1:0];
            end
            ST_DONE: decode_go = 1'b1;
            default: ;
        endcase
        bus_lanes = {bus_req, bus_req};
    end

    assign pc_out     = pc_q;
    assign supervisor = sup_q;
    assign int_mask   = mask_q;
    assign trace      = trace_q;
endmodule

// File: rtl/boot_vector_seq_chk.sv
module boot_vector_seq_chk #(
    parameter int ADDR_W        = 24,
    parameter int RESET_UCYC    = 7,
    parameter int HALF_PER_UCYC = 4,
    parameter int MASK_W        = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_prog,
    input logic              bus_ack,
    input logic [31:0]       pc_out,
    input logic              supervisor,
    input logic [MASK_W-1:0] int_mask,
    input logic              trace,
    input logic              decode_go
);
    localparam int FIRST_REQ = RESET_UCYC * HALF_PER_UCYC + 1;
    localparam int SC_W      = $clog2(FIRST_REQ + 1) + 1;

    logic [SC_W-1:0] since_rst;
    logic            finished;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            finished  <= 1'b0;
        end else begin
            if (since_rst < SC_W'(FIRST_REQ)) since_rst <= since_rst + 1'b1;
            if (decode_go) finished <= 1'b1;
        end
    end

    assert_idle_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> since_rst >= SC_W'(FIRST_REQ));

    assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_prog && bus_ack) |=> (pc_out == $past(pc_out) + 32'd2));

    assert_status_at_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        decode_go |-> (supervisor && int_mask == '1 && !trace));

    assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        decode_go |=> !decode_go);

    assert_quiet_after_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> !bus_req);
endmodule

bind boot_vector_seq boot_vector_seq_chk #(
    .ADDR_W(ADDR_W), .RESET_UCYC(RESET_UCYC),
    .HALF_PER_UCYC(HALF_PER_UCYC), .MASK_W(MASK_W)
) u_chk (.*);

// File: tb/boot_vector_seq_bench.sv
module boot_vector_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FIRST_REQ  = 29;
    localparam int GAP_CLKS   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req, bus_prog, bus_ack = 1'b0;
    logic [23:0] bus_addr;
    logic [1:0]  bus_lanes;
    logic [15:0] bus_rdata = '0;
    logic [31:0] a7_out, usp_out, pc_out;
    logic        supervisor, trace, decode_go;
    logic [2:0]  int_mask;
    logic [15:0] queue_hi, queue_lo;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] sp_vec, pc_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_vector_seq u_boot_vector_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_prog(bus_prog),
        .bus_lanes(bus_lanes), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .a7_out(a7_out), .usp_out(usp_out), .pc_out(pc_out),
        .supervisor(supervisor), .int_mask(int_mask), .trace(trace),
        .queue_hi(queue_hi), .queue_lo(queue_lo), .decode_go(decode_go)
    );

    function automatic logic [15:0] mem_word(input logic [23:0] a);
        case (a)
            24'd0:   return sp_vec[31:16];
            24'd2:   return sp_vec[15:0];
            24'd4:   return pc_vec[31:16];
            24'd6:   return pc_vec[15:0];
            default: return a[15:0] ^ 16'h5A5A;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset_state();
        apply_reset();
        chk(!bus_req && !decode_go, "R1 req/go", {bus_req, decode_go}, 0);
        chk(!supervisor, "R1 supervisor", supervisor, 0);
        chk(a7_out == 0 && pc_out == 0 && usp_out == 0, "R1 regs", a7_out | pc_out, 0);
    endtask

    // R2..R9, R11: complete boot with a given acknowledge delay
    task automatic t_boot(input int lat, input logic [31:0] sp, input logic [31:0] pc);
        logic [23:0] a_log [8];
        logic        p_log [8];
        int          st_log [8];
        int          ak_log [8];
        int n = 0, wc = 0, done_cyc = -1, dn = 0, post = 0, lanes_bad = 0, idle_bad = 0;
        logic st_sup = 0, st_tr = 1;
        logic [2:0] st_mask = 0;
        sp_vec = sp; pc_vec = pc;
        apply_reset();
        rst_n = 1'b1;
        for (int c = 1; c <= 600; c++) begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (c < FIRST_REQ && (bus_req || supervisor)) idle_bad++;
            if (decode_go) begin
                dn++;
                if (done_cyc < 0) done_cyc = c;
            end
            if (bus_req) begin
                if (done_cyc >= 0) post++;
                if (bus_lanes != 2'b11) lanes_bad++;
                if (wc == 0 && n < 8) st_log[n] = c;
                if (n == 0 && wc == 0) begin
                    st_sup = supervisor; st_mask = int_mask; st_tr = trace;
                end
                if (wc == lat) begin
                    if (n < 8) begin
                        a_log[n] = bus_addr; p_log[n] = bus_prog; ak_log[n] = c;
                    end
                    bus_rdata = mem_word(bus_addr);
                    bus_ack = 1'b1;
                    n++; wc = 0;
                end else wc++;
            end
            if (done_cyc >= 0 && c > done_cyc + 6) break;
        end
        bus_ack = 1'b0;
        chk(idle_bad == 0, "R2 quiet idle", idle_bad, 0);
        chk(n == 6, "R8 request count", n, 6);
        if (n < 6) return;
        chk(st_log[0] == FIRST_REQ, "R2 first request cycle", st_log[0], FIRST_REQ);
        chk(st_sup && st_mask == 3'd7 && !st_tr, "R3 status", {st_sup, st_mask, st_tr}, 4'b1110);
        for (int i = 0; i < 4; i++)
            chk(a_log[i] == 24'(2*i) && !p_log[i], "R4 vector addr/space", {p_log[i], a_log[i]}, 2*i);
        chk(a7_out == sp, "R4 stack pointer", a7_out, sp);
        chk(lanes_bad == 0, "R5 byte lanes", lanes_bad, 0);
        chk(a_log[4] == pc[23:0] && p_log[4], "R6 prefetch 1", a_log[4], pc[23:0]);
        chk(a_log[5] == 24'(pc + 2) && p_log[5], "R6 prefetch 2", a_log[5], pc + 2);
        chk(pc_out == pc + 4, "R6 final pc", pc_out, pc + 4);
        chk(queue_hi == mem_word(pc[23:0]), "R6 queue_hi", queue_hi, mem_word(pc[23:0]));
        chk(queue_lo == mem_word(24'(pc + 2)), "R6 queue_lo", queue_lo, mem_word(24'(pc + 2)));
        chk(st_log[5] - ak_log[4] == GAP_CLKS + 1, "R7 gap", st_log[5] - ak_log[4], GAP_CLKS + 1);
        chk(done_cyc == ak_log[5] + 1, "R8 strobe timing", done_cyc, ak_log[5] + 1);
        chk(dn == 1 && post == 0, "R8 single strobe, quiet after", {dn[15:0], post[15:0]}, 32'h10000);
        chk(usp_out == 0, "R9 user bank", usp_out, 0);
        chk(supervisor, "R11 supervisor held", supervisor, 1);
    endtask

    // R10: reset mid vector read restarts everything
    task automatic t_abort();
        int acks = 0, first = -1;
        sp_vec = 32'h0012_3456; pc_vec = 32'h0000_0400;
        apply_reset();
        rst_n = 1'b1;
        for (int c = 1; c <= 200 && acks < 2; c++) begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (bus_req) begin
                bus_rdata = mem_word(bus_addr);
                bus_ack = 1'b1;
                acks++;
            end
        end
        @(negedge clk);
        bus_ack = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(!bus_req, "R10 request dropped", bus_req, 0);
        chk(a7_out == 0 && !supervisor, "R10 cleared", a7_out, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 1; c <= 60 && first < 0; c++) begin
            @(negedge clk);
            if (bus_req) first = c;
        end
        chk(first == FIRST_REQ, "R10 restart idle", first, FIRST_REQ);
        chk(bus_addr == 0 && !bus_prog, "R10 restart addr", bus_addr, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_boot(0, 32'h00AB_CDEF, 32'h0000_1000);
        t_boot(2, 32'hFEDC_0010, 32'h0012_3456);
        t_boot(5, 32'h8000_7FFE, 32'h00FF_FFF0);
        t_abort();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule